// File: doc/BRIEF.md
# Posted Write Combining Buffer

This block sits between an upstream single-word request port and a downstream burst-write port, the way a bus bridge does. A memory write is acknowledged upstream in the same cycle it is stored. The downstream copy is issued later. The buffer holds `DEPTH` entries. As it stores writes, it links writes to ascending word addresses into one burst. It can bridge a gap of exactly one word with an empty filler beat. It folds a write into the newest waiting entry when both target the same word and their byte lanes do not collide. A write whose lanes collide with the waiting entry is never folded. It is kept as its own data phase, so both writes reach the far side in arrival order.

Reads are never posted. A read request waits until every earlier write has left the buffer. Only then is it offered downstream. The upstream side gets its acknowledge and data in the cycle the downstream completion arrives.

Downstream beats use a valid/ready handshake. Each beat carries its own word address and byte enables, plus a flag that marks the final beat of a burst. An entry is frozen once it reaches the head of the buffer, because the head is the beat on offer. Only a waiting entry behind the head can be extended or merged into.

Top module: `wpost_combiner`

## Requirements
- R1: A write request (`up_valid`=1, `up_write`=1) is acknowledged by `up_ready`=1 in the same cycle whenever the buffer is not full, even while the downstream port is stalled.
- R2: With `DEPTH` entries stored, a write that cannot merge sees `up_ready`=0 and is not stored. A write that merges into the newest entry is still accepted.
- R3: When at least two entries are stored, a write to the same word as the newest entry with disjoint byte enables is folded into that entry. The result is one beat whose byte enables are the OR of both, with each enabled lane carrying the data of the write that enabled it.
- R4: A write to the same word as the newest entry with overlapping byte enables is kept as a separate entry. It starts a new burst, and both beats appear in arrival order.
- R5: When at least two entries are stored, a write to the word directly above the newest entry joins its burst. Beats of a burst appear in arrival order, with `dn_last`=1 only on the final beat.
- R6: When at least two entries are stored, a write two words above the newest entry joins its burst behind a filler beat. The filler beat addresses the skipped word, has `dn_be`=0 and `dn_last`=0.
- R7: A write that is more than two words above the newest entry, or at a lower address, or arrives when fewer than two entries are stored, starts a new burst. The beat before it carries `dn_last`=1.
- R8: A read request is not offered downstream (`dn_rd_valid`=0) while any write beat remains. Once offered, it carries the upstream address, and no write beat is pending.
- R9: A read is acknowledged upstream (`up_ready`=1) only in the cycle `dn_rd_done`=1. In that cycle `up_rdata` equals `dn_rd_data`.
- R10: While `dn_valid`=1 and `dn_ready`=0, the beat's address, data, byte enables and last flag stay unchanged in the next cycle.
- R11: The entry at the head with nothing stored behind it is offered with `dn_last`=1.
- R12: After reset, `dn_valid`=0 and `dn_rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request present |
| up_write | input | 1 | 1 = memory write, 0 = read |
| up_addr | input | ADDR_W | Upstream word address |
| up_data | input | DATA_W | Write data |
| up_be | input | DATA_W/8 | Write byte enables |
| up_ready | output | 1 | Write posted, or read completed |
| up_rdata | output | DATA_W | Read data, valid with the read acknowledge |
| dn_valid | output | 1 | Write beat offered |
| dn_ready | input | 1 | Downstream takes the beat |
| dn_addr | output | ADDR_W | Beat word address |
| dn_data | output | DATA_W | Beat data |
| dn_be | output | DATA_W/8 | Beat byte enables |
| dn_last | output | 1 | Final beat of a burst |
| dn_rd_valid | output | 1 | Read request offered |
| dn_rd_ready | input | 1 | Downstream takes the read request |
| dn_rd_addr | output | ADDR_W | Read word address |
| dn_rd_done | input | 1 | Read completion |
| dn_rd_data | input | DATA_W | Completion data |

## Verification
The write acknowledge and every beat field depend combinationally on state. The bench drives inputs at the falling edge and samples one time unit later, in the same cycle, so it sees the acknowledge for the request it has just presented. The join decision is made against the buffer contents as they stood before that rising edge. The bench therefore holds `dn_ready` low while it posts a group, and it updates its expected entry list once per accepted write. A beat counts as transferred in the cycle the bench samples both valid and ready high. The read request appears one cycle after the buffer empties. The read acknowledge is checked in the very cycle the completion is driven, and it is checked to be absent in the cycles before.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    // How an incoming write relates to the newest stored entry
    typedef enum logic [1:0] {
        JOIN_NEW   = 2'd0,   // opens a new burst
        JOIN_MERGE = 2'd1,   // folded into the newest entry
        JOIN_NEXT  = 2'd2,   // next word of the same burst
        JOIN_SKIP  = 2'd3    // same burst after one filler beat
    } join_e;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_ASK  = 2'd1,
        RD_WAIT = 2'd2
    } rd_state_e;

    function automatic join_e pick_join(
        input logic tail_open,
        input logic same_word,
        input logic lanes_clash,
        input logic next_word,
        input logic skip_word
    );
        if (!tail_open)                return JOIN_NEW;
        if (same_word && !lanes_clash) return JOIN_MERGE;
        if (next_word)                 return JOIN_NEXT;
        if (skip_word)                 return JOIN_SKIP;
        return JOIN_NEW;
    endfunction

endpackage

// File: rtl/wpc_classify.sv
module wpc_classify
    import wpc_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 4
) (
    input  logic          tail_open,
    input  logic [AW-1:0] tail_addr,
    input  logic [BW-1:0] tail_be,
    input  logic [AW-1:0] in_addr,
    input  logic [BW-1:0] in_be,
    output join_e         act
);
    // one extra bit so that a wrap past the top word never counts as ascending
    logic [AW:0] tail_wide;
    logic [AW:0] in_wide;
    logic        same_word;
    logic        lanes_clash;
    logic        next_word;
    logic        skip_word;

    always_comb begin
        tail_wide   = {1'b0, tail_addr};
        in_wide     = {1'b0, in_addr};
        same_word   = (tail_addr == in_addr);
        lanes_clash = |(tail_be & in_be);
        next_word   = (in_wide == tail_wide + (AW+1)'(1));
        skip_word   = (in_wide == tail_wide + (AW+1)'(2));
        act         = pick_join(tail_open, same_word, lanes_clash, next_word, skip_word);
    end

endmodule

// File: rtl/wpc_store.sv
module wpc_store #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int BW    = 4,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         merge,
    input  logic                         pop,
    input  logic [AW-1:0]                in_addr,
    input  logic [DW-1:0]                in_data,
    input  logic [BW-1:0]                in_be,
    input  logic                         in_start,
    input  logic                         in_gap,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [AW-1:0]                tail_addr,
    output logic [BW-1:0]                tail_be,
    output logic [AW-1:0]                hd_addr,
    output logic [DW-1:0]                hd_data,
    output logic [BW-1:0]                hd_be,
    output logic                         hd_gap,
    output logic                         nx_start
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH-1);

    logic [AW-1:0] e_addr  [DEPTH];
    logic [DW-1:0] e_data  [DEPTH];
    logic [BW-1:0] e_be    [DEPTH];
    logic          e_start [DEPTH];
    logic          e_gap   [DEPTH];

    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [PW-1:0] tp;
    logic [PW-1:0] rp_nx;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        tp    = (wp == '0) ? LAST_IDX : wp - PW'(1);
        rp_nx = step(rp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= rp_nx;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            e_addr[wp]  <= in_addr;
            e_data[wp]  <= in_data;
            e_be[wp]    <= in_be;
            e_start[wp] <= in_start;
            e_gap[wp]   <= in_gap;
        end
        if (merge) begin
            for (int g = 0; g < BW; g++) begin
                if (in_be[g]) e_data[tp][g*8 +: 8] <= in_data[g*8 +: 8];
            end
            e_be[tp] <= e_be[tp] | in_be;
        end
    end

    always_comb begin
        tail_addr = e_addr[tp];
        tail_be   = e_be[tp];
        hd_addr   = e_addr[rp];
        hd_data   = e_data[rp];
        hd_be     = e_be[rp];
        hd_gap    = e_gap[rp];
        nx_start  = e_start[rp_nx];
    end

endmodule

// File: rtl/wpc_issue.sv
module wpc_issue #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          have_head,
    input  logic          only_one,
    input  logic [AW-1:0] hd_addr,
    input  logic [DW-1:0] hd_data,
    input  logic [BW-1:0] hd_be,
    input  logic          hd_gap,
    input  logic          nx_start,
    input  logic          dn_ready,
    output logic          dn_valid,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_data,
    output logic [BW-1:0] dn_be,
    output logic          dn_last,
    output logic          pop
);
    logic fill_done;
    logic in_fill;

    always_comb begin
        in_fill  = hd_gap && !fill_done;
        dn_valid = have_head;
        if (in_fill) begin
            dn_addr = hd_addr - AW'(1);
            dn_data = '0;
            dn_be   = '0;
            dn_last = 1'b0;
        end else begin
            dn_addr = hd_addr;
            dn_data = hd_data;
            dn_be   = hd_be;
            dn_last = only_one || nx_start;
        end
        pop = have_head && dn_ready && !in_fill;
    end

    always_ff @(posedge clk) begin
        if (rst)                        fill_done <= 1'b0;
        else if (have_head && dn_ready) fill_done <= in_fill;
    end

endmodule

// File: rtl/wpc_rdpath.sv
module wpc_rdpath
    import wpc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic          wr_empty,
    input  logic          dn_rd_ready,
    input  logic          dn_rd_done,
    input  logic [DW-1:0] dn_rd_data,
    output logic          dn_rd_valid,
    output logic          rd_ack,
    output logic [DW-1:0] rd_data
);
    rd_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= RD_IDLE;
        end else begin
            unique case (st)
                RD_IDLE: if (rd_req && wr_empty) st <= RD_ASK;
                RD_ASK:  if (dn_rd_ready)        st <= RD_WAIT;
                RD_WAIT: if (dn_rd_done)         st <= RD_IDLE;
                default:                         st <= RD_IDLE;
            endcase
        end
    end

    always_comb begin
        dn_rd_valid = (st == RD_ASK);
        rd_ack      = (st == RD_WAIT) && dn_rd_done;
        rd_data     = dn_rd_data;
    end

endmodule

// File: rtl/wpost_combiner.sv
module wpost_combiner
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 up_valid,
    input  logic                 up_write,
    input  logic [ADDR_W-1:0]    up_addr,
    input  logic [DATA_W-1:0]    up_data,
    input  logic [DATA_W/8-1:0]  up_be,
    output logic                 up_ready,
    output logic [DATA_W-1:0]    up_rdata,
    output logic                 dn_valid,
    input  logic                 dn_ready,
    output logic [ADDR_W-1:0]    dn_addr,
    output logic [DATA_W-1:0]    dn_data,
    output logic [DATA_W/8-1:0]  dn_be,
    output logic                 dn_last,
    output logic                 dn_rd_valid,
    input  logic                 dn_rd_ready,
    output logic [ADDR_W-1:0]    dn_rd_addr,
    input  logic                 dn_rd_done,
    input  logic [DATA_W-1:0]    dn_rd_data
);
    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  fill_cnt;
    logic [ADDR_W-1:0] tail_addr;
    logic [BE_W-1:0]   tail_be;
    logic [ADDR_W-1:0] hd_addr;
    logic [DATA_W-1:0] hd_data;
    logic [BE_W-1:0]   hd_be;
    logic              hd_gap;
    logic              nx_start;
    logic              full;
    logic              tail_open;
    logic              wr_take;
    logic              push;
    logic              merge;
    logic              pop;
    logic              rd_ack;
    join_e             act;

    always_comb begin
        full      = (fill_cnt == CNT_W'(DEPTH));
        // the head is on offer and frozen, so joining needs a waiting entry behind it
        tail_open = (fill_cnt >= CNT_W'(2));
        up_ready  = up_write ? ((act == JOIN_MERGE) || !full) : rd_ack;
        wr_take   = up_valid && up_write && up_ready;
        merge     = wr_take && (act == JOIN_MERGE);
        push      = wr_take && (act != JOIN_MERGE);
        dn_rd_addr = up_addr;
    end

    wpc_classify #(.AW(ADDR_W), .BW(BE_W)) u_classify (
        .tail_open (tail_open),
        .tail_addr (tail_addr),
        .tail_be   (tail_be),
        .in_addr   (up_addr),
        .in_be     (up_be),
        .act       (act)
    );

    wpc_store #(.AW(ADDR_W), .DW(DATA_W), .BW(BE_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .merge     (merge),
        .pop       (pop),
        .in_addr   (up_addr),
        .in_data   (up_data),
        .in_be     (up_be),
        .in_start  (act == JOIN_NEW),
        .in_gap    (act == JOIN_SKIP),
        .count     (fill_cnt),
        .tail_addr (tail_addr),
        .tail_be   (tail_be),
        .hd_addr   (hd_addr),
        .hd_data   (hd_data),
        .hd_be     (hd_be),
        .hd_gap    (hd_gap),
        .nx_start  (nx_start)
    );

    wpc_issue #(.AW(ADDR_W), .DW(DATA_W), .BW(BE_W)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .have_head (fill_cnt != '0),
        .only_one  (fill_cnt == CNT_W'(1)),
        .hd_addr   (hd_addr),
        .hd_data   (hd_data),
        .hd_be     (hd_be),
        .hd_gap    (hd_gap),
        .nx_start  (nx_start),
        .dn_ready  (dn_ready),
        .dn_valid  (dn_valid),
        .dn_addr   (dn_addr),
        .dn_data   (dn_data),
        .dn_be     (dn_be),
        .dn_last   (dn_last),
        .pop       (pop)
    );

    wpc_rdpath #(.DW(DATA_W)) u_rdpath (
        .clk         (clk),
        .rst         (rst),
        .rd_req      (up_valid && !up_write),
        .wr_empty    (fill_cnt == '0),
        .dn_rd_ready (dn_rd_ready),
        .dn_rd_done  (dn_rd_done),
        .dn_rd_data  (dn_rd_data),
        .dn_rd_valid (dn_rd_valid),
        .rd_ack      (rd_ack),
        .rd_data     (up_rdata)
    );

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       up_valid,
    input logic                       up_write,
    input logic                       up_ready,
    input logic                       dn_valid,
    input logic                       dn_ready,
    input logic [AW-1:0]              dn_addr,
    input logic [DW-1:0]              dn_data,
    input logic [DW/8-1:0]            dn_be,
    input logic                       dn_last,
    input logic                       dn_rd_valid,
    input logic                       dn_rd_done,
    input logic [$clog2(DEPTH+1)-1:0] fill_cnt
);
    AST_POST_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_write && fill_cnt == '0) |-> up_ready); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R2

    AST_FILLER_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_be == '0) |-> !dn_last); // R6

    AST_READ_BEHIND_WRITES: assert property (@(posedge clk) disable iff (rst)
        dn_rd_valid |-> !dn_valid); // R8

    AST_READ_ACK_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_write && up_ready) |-> dn_rd_done); // R9

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_data)
                                     && $stable(dn_be) && $stable(dn_last))); // R10
endmodule

bind wpost_combiner wpc_checker #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_wpc_checker (
    .clk         (clk),
    .rst         (rst),
    .up_valid    (up_valid),
    .up_write    (up_write),
    .up_ready    (up_ready),
    .dn_valid    (dn_valid),
    .dn_ready    (dn_ready),
    .dn_addr     (dn_addr),
    .dn_data     (dn_data),
    .dn_be       (dn_be),
    .dn_last     (dn_last),
    .dn_rd_valid (dn_rd_valid),
    .dn_rd_done  (dn_rd_done),
    .fill_cnt    (fill_cnt)
);

// File: tb/test_wpost_combiner.sv
module test_wpost_combiner;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          up_valid = 1'b0;
    logic          up_write = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic [DW-1:0] up_data = '0;
    logic [BW-1:0] up_be = '0;
    logic          up_ready;
    logic [DW-1:0] up_rdata;
    logic          dn_valid;
    logic          dn_ready = 1'b0;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_data;
    logic [BW-1:0] dn_be;
    logic          dn_last;
    logic          dn_rd_valid;
    logic          dn_rd_ready = 1'b1;
    logic [AW-1:0] dn_rd_addr;
    logic          dn_rd_done = 1'b0;
    logic [DW-1:0] dn_rd_data = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wpost_combiner #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) i_wpost_combiner (
        .clk(clk), .rst(rst),
        .up_valid(up_valid), .up_write(up_write), .up_addr(up_addr),
        .up_data(up_data), .up_be(up_be), .up_ready(up_ready), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
        .dn_data(dn_data), .dn_be(dn_be), .dn_last(dn_last),
        .dn_rd_valid(dn_rd_valid), .dn_rd_ready(dn_rd_ready), .dn_rd_addr(dn_rd_addr),
        .dn_rd_done(dn_rd_done), .dn_rd_data(dn_rd_data)
    );

    // expected entries of the buffer
    logic [AW-1:0] m_addr  [16];
    logic [DW-1:0] m_data  [16];
    logic [BW-1:0] m_be    [16];
    bit            m_start [16];
    bit            m_gap   [16];
    int            mc = 0;

    // expected beats
    logic [AW-1:0] x_addr [64];
    logic [DW-1:0] x_data [64];
    logic [BW-1:0] x_be   [64];
    bit            x_last [64];
    int            nx = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // apply the joining rules of R1..R7 to the expected entry list
    function automatic bit model_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
        bit st = 1'b1;
        bit gp = 1'b0;
        if (mc >= 2 && a == m_addr[mc-1] && (b & m_be[mc-1]) == '0) begin
            for (int g = 0; g < BW; g++)
                if (b[g]) m_data[mc-1][g*8 +: 8] = d[g*8 +: 8];
            m_be[mc-1] = m_be[mc-1] | b;
            return 1'b1;
        end
        if (mc == DEPTH) return 1'b0;
        if (mc >= 2) begin
            if ({1'b0, a} == {1'b0, m_addr[mc-1]} + 17'd1) st = 1'b0;
            else if ({1'b0, a} == {1'b0, m_addr[mc-1]} + 17'd2) begin st = 1'b0; gp = 1'b1; end
        end
        m_addr[mc] = a; m_data[mc] = d; m_be[mc] = b; m_start[mc] = st; m_gap[mc] = gp;
        mc++;
        return 1'b1;
    endfunction

    function automatic void build_exp();
        nx = 0;
        for (int i = 0; i < mc; i++) begin
            if (m_gap[i]) begin
                x_addr[nx] = m_addr[i] - AW'(1); x_data[nx] = '0; x_be[nx] = '0; x_last[nx] = 1'b0;
                nx++;
            end
            x_addr[nx] = m_addr[i]; x_data[nx] = m_data[i]; x_be[nx] = m_be[i];
            x_last[nx] = (i == mc - 1) || m_start[i+1];
            nx++;
        end
    endfunction

    task automatic post(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
        bit exp_acc;
        bit was_full;
        @(negedge clk);
        up_valid = 1'b1; up_write = 1'b1; up_addr = a; up_data = d; up_be = b;
        #1;
        was_full = (mc == DEPTH);
        exp_acc = model_write(a, d, b);
        chk(up_ready == exp_acc, was_full ? "R2 write acknowledge when full" : "R1 write acknowledge",
            64'(up_ready), 64'(exp_acc));
    endtask

    task automatic end_group();
        @(negedge clk);
        up_valid = 1'b0; up_write = 1'b0;
    endtask

    task automatic drain(input string tag);
        int idx = 0;
        bit held = 1'b0;
        logic [AW-1:0] h_addr; logic [DW-1:0] h_data; logic [BW-1:0] h_be; logic h_last;
        build_exp();
        for (int cyc = 0; cyc < 600 && idx < nx; cyc++) begin
            @(negedge clk);
            dn_ready = ($urandom % 4) != 0;
            #1;
            if (held) begin
                chk(dn_valid && dn_addr == h_addr && dn_data == h_data && dn_be == h_be && dn_last == h_last,
                    "R10 stalled beat held", {dn_addr, dn_data}, {h_addr, h_data});
            end
            held = dn_valid && !dn_ready;
            h_addr = dn_addr; h_data = dn_data; h_be = dn_be; h_last = dn_last;
            if (dn_valid && dn_ready) begin
                chk(dn_addr == x_addr[idx], {tag, " beat address"}, 64'(dn_addr), 64'(x_addr[idx]));
                chk(dn_data == x_data[idx] && dn_be == x_be[idx], {tag, " beat data/lanes"},
                    {dn_be, dn_data}, {x_be[idx], x_data[idx]});
                chk(dn_last == x_last[idx], {tag, " beat last flag"}, 64'(dn_last), 64'(x_last[idx]));
                idx++;
            end
        end
        chk(idx == nx, {tag, " beat count"}, 64'(idx), 64'(nx));
        @(negedge clk);
        dn_ready = 1'b0;
        #1;
        chk(!dn_valid, {tag, " empty after drain"}, 64'(dn_valid), 64'd0);
        mc = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [AW-1:0] a;
        void'($urandom(32'd20250611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!dn_valid && !dn_rd_valid, "R12 reset state", {dn_valid, dn_rd_valid}, 64'd0);

        // R11: a lone write is a burst of one
        post(16'h0300, 32'hAABBCCDD, 4'hF);
        end_group();
        drain("R11 lone write");

        // R3 merge, R4 overlap kept separate
        post(16'h0100, 32'h11111111, 4'hF);
        post(16'h0010, 32'h000000A1, 4'h3);
        post(16'h0010, 32'hB2C30000, 4'hC);
        post(16'h0010, 32'h000000D4, 4'h1);
        end_group();
        drain("R3 R4 merge and overlap");

        // R5 ascending, R6 one-word gap, R7 large gap and descent
        post(16'h0200, 32'h0, 4'hF);
        post(16'h0020, 32'h20, 4'hF);
        post(16'h0021, 32'h21, 4'h3);
        post(16'h0022, 32'h22, 4'hF);
        post(16'h0024, 32'h24, 4'h8);
        post(16'h0028, 32'h28, 4'hF);
        post(16'h0027, 32'h27, 4'hF);
        end_group();
        drain("R5 R6 R7 burst shaping");

        // R2: fill the buffer, reject one, still accept a merge
        for (int i = 0; i < DEPTH + 1; i++) post(AW'(16'h0400 + 4 * i), DW'(i), 4'h1);
        post(AW'(16'h0400 + 4 * (DEPTH - 1)), 32'h0000EE00, 4'h2);
        end_group();
        drain("R2 full buffer");

        // random groups
        for (int g = 0; g < 40; g++) begin
            int n = 1 + ($urandom % 12);
            a = AW'($urandom);
            for (int k = 0; k < n; k++) begin
                case ($urandom % 8)
                    0, 1: a = a;
                    2, 3: a = a + AW'(1);
                    4:    a = a + AW'(2);
                    5:    a = a + AW'(3);
                    6:    a = a - AW'(1);
                    default: a = AW'($urandom);
                endcase
                post(a, $urandom, BW'(1 + ($urandom % 15)));
            end
            end_group();
            drain("R3 R4 R5 R6 R7 random group");
        end

        // R8 read waits behind posted writes, R9 completion
        post(16'h0500, 32'h5, 4'hF);
        post(16'h0501, 32'h6, 4'hF);
        post(16'h0502, 32'h7, 4'hF);
        @(negedge clk);
        up_valid = 1'b1; up_write = 1'b0; up_addr = 16'h0055;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1;
            chk(!dn_rd_valid, "R8 read held behind writes", 64'(dn_rd_valid), 64'd0);
            chk(!up_ready, "R9 no read acknowledge before completion", 64'(up_ready), 64'd0);
        end
        dn_ready = 1'b1;
        for (int i = 0; i < 50 && !dn_rd_valid; i++) begin
            @(negedge clk);
            #1;
        end
        chk(dn_rd_valid, "R8 read offered after drain", 64'(dn_rd_valid), 64'd1);
        chk(!dn_valid, "R8 no write beat left", 64'(dn_valid), 64'd0);
        chk(dn_rd_addr == 16'h0055, "R8 read address", 64'(dn_rd_addr), 64'h55);
        dn_ready = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            #1;
            chk(!up_ready, "R9 read waits for completion", 64'(up_ready), 64'd0);
        end
        @(negedge clk);
        dn_rd_done = 1'b1; dn_rd_data = 32'hCAFE0123;
        #1;
        chk(up_ready, "R9 read acknowledge on completion", 64'(up_ready), 64'd1);
        chk(up_rdata == 32'hCAFE0123, "R9 read data", 64'(up_rdata), 64'hCAFE0123);
        @(negedge clk);
        dn_rd_done = 1'b0; up_valid = 1'b0;
        mc = 0;
        #1;
        chk(!dn_rd_valid, "R9 read closed", 64'(dn_rd_valid), 64'd0);

        finish_run();
    end

endmodule